// File: doc/BRIEF.md
# Paged Network Controller Register Bank

This block is the host-side register bank of a small network controller. A host reaches it through a 4-bit address with byte-wide write and read data. Address 0 always selects the command register. Every other address is combined with a page number held in the two top bits of the command register, which gives up to three register pages. The bank holds the controller's settings: receive ring limits, the boundary and current-page pointers, the transmit page and length, the remote address and count, the receive and data settings, the interrupt mask and the six station address bytes.

The bank also holds the interrupt status byte and drives one level-sensitive interrupt line from it. Writing the command register can have immediate side effects. A transmit request raises a one-cycle start pulse, which comes out together with the programmed page and length, and then completes at once. A remote transfer requested with a zero byte count completes at once. Two event inputs report a received frame and an externally finished transmission. A small control machine tracks the run state. It has three states. CTL_RESET holds from reset until the first command write with the stop bit clear (transition go-from-reset leads to CTL_RUN). In CTL_RUN, a command write with stop set takes the halt transition to CTL_HALT. From CTL_HALT, a command write with stop clear takes the resume transition back to CTL_RUN. A stop-set write in CTL_RESET leaves the machine in CTL_RESET.

Top module: `nic_page_regs`

## Requirements
- R1: Address 0 always reads and writes the command register. Any other address selects effective offset {command[7:6], addr}. Page 3 (command[7:6]=3) holds no registers: its reads return 0 and its writes change nothing.
- R2: The transmit length, remote address and remote count are 16 bits wide. Each is written as a low byte (page 0 offsets 5, 8, 10) and a high byte (offsets 6, 9, 11), and each byte write keeps the other byte unchanged.
- R3: After reset the command reads 0x01, interrupt status reads 0x80, and transmit status and all other registers read 0. Any command write with bit 0 (stop) clear clears status bit 7. Nothing but reset sets bit 7 again.
- R4: A command write with stop clear and bit 3 (remote read) or bit 4 (remote write) set, made while the remote count is 0, sets status bit 6 on that edge. With a nonzero count, or with stop set, the write does not set bit 6.
- R5: A command write with stop clear and bit 2 (transmit) set does four things. It sets transmit status (page 0 offset 4 read) to 0x01. It sets status bit 1. It stores the command with bit 2 cleared. It drives tx_start_o high for exactly the next cycle, with tx_page_o/tx_len_o carrying the programmed page and length.
- R6: A write to page 0 offset 7 clears every status bit in [6:0] whose write-data bit is 1. Bit 7 is not affected.
- R7: irq_o is high exactly when (status AND mask AND 0x7F) is nonzero. The mask is at page 0 offset 15. irq_o follows any mask or status change from the same clock edge.
- R8: rx_done_i sets status bit 0 only while the controller runs (last command had stop clear). While stopped it is ignored. tx_done_i sets status bit 1 and transmit status 0x01.
- R9: When an event sets a status bit in the same cycle as a host write clears it, the bit ends set.
- R10: Page 1 offsets 1..6 are the station address bytes and offset 7 is the current page, all read/write. Page 2 reads back ring start (1), ring stop (2), transmit page (4), receive settings (12), data settings (14) and mask (15), and ignores writes.
- R11: Page 0 reads return boundary (3), transmit status (4), interrupt status (7) and remote address low/high (8/9). Every other page 0 read, including the write-only ring start and stop (1/2), returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| wr_en | input | 1 | Host write strobe for one cycle |
| addr | input | 4 | Host register address |
| wdata | input | 8 | Host write data |
| rdata | output | 8 | Read data for addr (combinational) |
| rx_done_i | input | 1 | Frame received event, one cycle |
| tx_done_i | input | 1 | Transmission finished event, one cycle |
| irq_o | output | 1 | Level interrupt |
| tx_start_o | output | 1 | One-cycle transmit start pulse |
| tx_page_o | output | 8 | Transmit start page |
| tx_len_o | output | 16 | Transmit byte length |

## Verification
The assertions take for granted that the event inputs and the write strobe are single-cycle pulses. They also assume that transmit commands are not written on back-to-back cycles, so each start pulse stands alone. The bench keeps to this. Every host access goes through tasks that raise the strobe for exactly one cycle. Events are pulsed for one cycle between accesses, except in the one test that deliberately puts an event in the same cycle as a status clear. Page switches in the register sweep use stop-set commands with no remote or transmit bits, so only the intended side effects ever occur.

// File: rtl/nic_regs_pkg.sv
package nic_regs_pkg;

    localparam int DATA_W  = 8;
    localparam int ADDR_W  = 4;
    localparam int PAGE_W  = 2;
    localparam int OFF_W   = ADDR_W + PAGE_W;

    typedef enum logic [1:0] {
        CTL_RESET = 2'd0,
        CTL_RUN   = 2'd1,
        CTL_HALT  = 2'd2
    } ctl_state_e;

    // command bits
    localparam int CMD_STOP  = 0;
    localparam int CMD_START = 1;
    localparam int CMD_TX    = 2;
    localparam int CMD_RRD   = 3;
    localparam int CMD_RWR   = 4;

    // interrupt status bits
    localparam int ISR_RX  = 0;
    localparam int ISR_TX  = 1;
    localparam int ISR_RDC = 6;
    localparam int ISR_RST = 7;

    localparam logic [DATA_W-1:0] IRQ_LIVE_MASK = 8'h7F;
    localparam logic [DATA_W-1:0] CMD_RESET_VAL = 8'h01;
    localparam logic [DATA_W-1:0] TSR_SENT      = 8'h01;

    // effective offsets {page, addr}
    localparam logic [OFF_W-1:0] OFF_RING_LO_W = 6'h01;
    localparam logic [OFF_W-1:0] OFF_RING_HI_W = 6'h02;
    localparam logic [OFF_W-1:0] OFF_BOUND     = 6'h03;
    localparam logic [OFF_W-1:0] OFF_TXPG      = 6'h04;
    localparam logic [OFF_W-1:0] OFF_TXLEN_L   = 6'h05;
    localparam logic [OFF_W-1:0] OFF_TXLEN_H   = 6'h06;
    localparam logic [OFF_W-1:0] OFF_IRQST     = 6'h07;
    localparam logic [OFF_W-1:0] OFF_RADDR_L   = 6'h08;
    localparam logic [OFF_W-1:0] OFF_RADDR_H   = 6'h09;
    localparam logic [OFF_W-1:0] OFF_RCNT_L    = 6'h0A;
    localparam logic [OFF_W-1:0] OFF_RCNT_H    = 6'h0B;
    localparam logic [OFF_W-1:0] OFF_RXSET     = 6'h0C;
    localparam logic [OFF_W-1:0] OFF_DSET      = 6'h0E;
    localparam logic [OFF_W-1:0] OFF_IMASK     = 6'h0F;
    localparam logic [OFF_W-1:0] OFF_STA0      = 6'h11;
    localparam logic [OFF_W-1:0] OFF_CURPG     = 6'h17;
    localparam logic [OFF_W-1:0] OFF_RING_LO_R = 6'h21;
    localparam logic [OFF_W-1:0] OFF_RING_HI_R = 6'h22;
    localparam logic [OFF_W-1:0] OFF_TXPG_R    = 6'h24;
    localparam logic [OFF_W-1:0] OFF_RXSET_R   = 6'h2C;
    localparam logic [OFF_W-1:0] OFF_DSET_R    = 6'h2E;
    localparam logic [OFF_W-1:0] OFF_IMASK_R   = 6'h2F;

endpackage

// File: rtl/nic_cmd_ctrl.sv
module nic_cmd_ctrl
    import nic_regs_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_we_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic              rcnt_zero_i,
    output logic [DATA_W-1:0] cmd_o,
    output logic              running_o,
    output logic              clr_rst_o,
    output logic              set_rdc_o,
    output logic              set_tx_o,
    output logic              tx_start_o
);

    ctl_state_e state_q, state_n;
    logic [DATA_W-1:0] cmd_q;
    logic              go;
    logic              tx_req;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= CTL_RESET;
        end else begin
            state_q <= state_n;
        end
    end

    always_comb begin
        state_n = state_q;
        unique case (state_q)
            CTL_RESET: if (cmd_we_i && !wdata_i[CMD_STOP]) state_n = CTL_RUN;
            CTL_RUN:   if (cmd_we_i &&  wdata_i[CMD_STOP]) state_n = CTL_HALT;
            CTL_HALT:  if (cmd_we_i && !wdata_i[CMD_STOP]) state_n = CTL_RUN;
            default:   state_n = CTL_RESET;
        endcase
    end

    // outputs and side-effect strobes
    always_comb begin
        go        = cmd_we_i && !wdata_i[CMD_STOP];
        tx_req    = go && wdata_i[CMD_TX];
        clr_rst_o = go;
        set_rdc_o = go && (wdata_i[CMD_RRD] || wdata_i[CMD_RWR]) && rcnt_zero_i;
        set_tx_o  = tx_req;
        running_o = (state_q == CTL_RUN);
        cmd_o     = cmd_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cmd_q      <= CMD_RESET_VAL;
            tx_start_o <= 1'b0;
        end else begin
            tx_start_o <= tx_req;
            if (cmd_we_i) begin
                cmd_q <= tx_req ? (wdata_i & ~(DATA_W'(1) << CMD_TX)) : wdata_i;
            end
        end
    end

    assert_tx_selfclear_R5: assert property (@(posedge clk) disable iff (!rst_n)
        tx_start_o |-> !cmd_q[CMD_TX]);

    assert_state_tracks_stop_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == CTL_RUN) |-> !cmd_q[CMD_STOP]);

endmodule

// File: rtl/nic_irq_unit.sv
module nic_irq_unit
    import nic_regs_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] set_vec_i,
    input  logic              clr_we_i,
    input  logic [DATA_W-1:0] clr_mask_i,
    input  logic              clr_rst_i,
    input  logic [DATA_W-1:0] imr_i,
    output logic [DATA_W-1:0] isr_o,
    output logic              irq_o
);

    logic [DATA_W-1:0] isr_q;

    for (genvar gi = 0; gi < DATA_W; gi++) begin : g_bit
        if (gi == ISR_RST) begin : g_rst_bit
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    isr_q[gi] <= 1'b1;
                end else if (clr_rst_i) begin
                    isr_q[gi] <= 1'b0;
                end
            end
        end else begin : g_evt_bit
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    isr_q[gi] <= 1'b0;
                end else if (set_vec_i[gi]) begin
                    isr_q[gi] <= 1'b1;
                end else if (clr_we_i && clr_mask_i[gi]) begin
                    isr_q[gi] <= 1'b0;
                end
            end
        end
    end

    always_comb begin
        isr_o = isr_q;
        irq_o = |(isr_q & imr_i & IRQ_LIVE_MASK);
    end

    assert_rstbit_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !isr_q[ISR_RST] |=> !isr_q[ISR_RST]);

    assert_clear_works_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_we_i && set_vec_i == '0) |=> ((isr_q & $past(clr_mask_i) & IRQ_LIVE_MASK) == '0));

    assert_set_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
        set_vec_i[ISR_RX] |=> isr_q[ISR_RX]);

    assert_mask_off_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ((imr_i & IRQ_LIVE_MASK) == '0) |-> !irq_o);

endmodule

// File: rtl/nic_reg_file.sv
module nic_reg_file
    import nic_regs_pkg::*;
#(
    parameter int STATION_BYTES = 6
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                we_i,
    input  logic [OFF_W-1:0]    off_i,
    input  logic [DATA_W-1:0]   wdata_i,
    input  logic                tsr_set_i,
    input  logic [DATA_W-1:0]   isr_i,
    output logic [DATA_W-1:0]   rdata_o,
    output logic [DATA_W-1:0]   imr_o,
    output logic                rcnt_zero_o,
    output logic [DATA_W-1:0]   tx_page_o,
    output logic [2*DATA_W-1:0] tx_len_o
);

    localparam int CNT_W = 2 * DATA_W;

    logic [DATA_W-1:0] ring_lo_q, ring_hi_q, bound_q, txpg_q, tsr_q;
    logic [DATA_W-1:0] rxset_q, dset_q, imask_q, curpg_q;
    logic [CNT_W-1:0]  txlen_q, raddr_q, rcnt_q;
    logic [DATA_W-1:0] sta_q [STATION_BYTES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ring_lo_q <= '0;
            ring_hi_q <= '0;
            bound_q   <= '0;
            txpg_q    <= '0;
            rxset_q   <= '0;
            dset_q    <= '0;
            imask_q   <= '0;
            curpg_q   <= '0;
            txlen_q   <= '0;
            raddr_q   <= '0;
            rcnt_q    <= '0;
        end else if (we_i) begin
            case (off_i)
                OFF_RING_LO_W: ring_lo_q <= wdata_i;
                OFF_RING_HI_W: ring_hi_q <= wdata_i;
                OFF_BOUND:     bound_q   <= wdata_i;
                OFF_TXPG:      txpg_q    <= wdata_i;
                OFF_TXLEN_L:   txlen_q   <= {txlen_q[CNT_W-1:DATA_W], wdata_i};
                OFF_TXLEN_H:   txlen_q   <= {wdata_i, txlen_q[DATA_W-1:0]};
                OFF_RADDR_L:   raddr_q   <= {raddr_q[CNT_W-1:DATA_W], wdata_i};
                OFF_RADDR_H:   raddr_q   <= {wdata_i, raddr_q[DATA_W-1:0]};
                OFF_RCNT_L:    rcnt_q    <= {rcnt_q[CNT_W-1:DATA_W], wdata_i};
                OFF_RCNT_H:    rcnt_q    <= {wdata_i, rcnt_q[DATA_W-1:0]};
                OFF_RXSET:     rxset_q   <= wdata_i;
                OFF_DSET:      dset_q    <= wdata_i;
                OFF_IMASK:     imask_q   <= wdata_i;
                OFF_CURPG:     curpg_q   <= wdata_i;
                default: ;
            endcase
        end
    end

    // transmit status: set by completion, never host-written
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tsr_q <= '0;
        end else if (tsr_set_i) begin
            tsr_q <= TSR_SENT;
        end
    end

    for (genvar gi = 0; gi < STATION_BYTES; gi++) begin : g_sta
        localparam logic [OFF_W-1:0] MY_OFF = OFF_W'(int'(OFF_STA0) + gi);
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                sta_q[gi] <= '0;
            end else if (we_i && off_i == MY_OFF) begin
                sta_q[gi] <= wdata_i;
            end
        end
    end

    always_comb begin
        rdata_o = '0;
        case (off_i)
            OFF_BOUND:     rdata_o = bound_q;
            OFF_TXPG:      rdata_o = tsr_q;
            OFF_IRQST:     rdata_o = isr_i;
            OFF_RADDR_L:   rdata_o = raddr_q[DATA_W-1:0];
            OFF_RADDR_H:   rdata_o = raddr_q[CNT_W-1:DATA_W];
            OFF_CURPG:     rdata_o = curpg_q;
            OFF_RING_LO_R: rdata_o = ring_lo_q;
            OFF_RING_HI_R: rdata_o = ring_hi_q;
            OFF_TXPG_R:    rdata_o = txpg_q;
            OFF_RXSET_R:   rdata_o = rxset_q;
            OFF_DSET_R:    rdata_o = dset_q;
            OFF_IMASK_R:   rdata_o = imask_q;
            default:       rdata_o = '0;
        endcase
        for (int i = 0; i < STATION_BYTES; i++) begin
            if (off_i == OFF_W'(int'(OFF_STA0) + i)) rdata_o = sta_q[i];
        end
    end

    always_comb begin
        imr_o       = imask_q;
        rcnt_zero_o = (rcnt_q == '0);
        tx_page_o   = txpg_q;
        tx_len_o    = txlen_q;
    end

    assert_tsr_sent_R5: assert property (@(posedge clk) disable iff (!rst_n)
        tsr_set_i |=> (tsr_q == TSR_SENT));

    assert_page3_inert_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (we_i && off_i[OFF_W-1 -: PAGE_W] == 2'b11) |=> $stable(imask_q) && $stable(bound_q));

endmodule

// File: rtl/nic_page_regs.sv
module nic_page_regs
    import nic_regs_pkg::*;
#(
    parameter int STATION_BYTES = 6
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  logic [3:0]   addr,
    input  logic [7:0]   wdata,
    output logic [7:0]   rdata,
    input  logic         rx_done_i,
    input  logic         tx_done_i,
    output logic         irq_o,
    output logic         tx_start_o,
    output logic [7:0]   tx_page_o,
    output logic [15:0]  tx_len_o
);

    logic [DATA_W-1:0] cmd_q, isr_q, imr_q, file_rdata;
    logic [DATA_W-1:0] set_vec;
    logic [OFF_W-1:0]  eff_off;
    logic cmd_we, reg_we, isr_we;
    logic running, clr_rst, set_rdc, set_tx, rcnt_zero;

    always_comb begin
        eff_off = {cmd_q[DATA_W-1 -: PAGE_W], addr};
        cmd_we  = wr_en && (addr == '0);
        reg_we  = wr_en && (addr != '0);
        isr_we  = reg_we && (eff_off == OFF_IRQST);
        set_vec = '0;
        set_vec[ISR_RX]  = rx_done_i && running;
        set_vec[ISR_TX]  = set_tx || tx_done_i;
        set_vec[ISR_RDC] = set_rdc;
        rdata   = (addr == '0) ? cmd_q : file_rdata;
    end

    nic_cmd_ctrl u_cmd (
        .clk         (clk),
        .rst_n       (rst_n),
        .cmd_we_i    (cmd_we),
        .wdata_i     (wdata),
        .rcnt_zero_i (rcnt_zero),
        .cmd_o       (cmd_q),
        .running_o   (running),
        .clr_rst_o   (clr_rst),
        .set_rdc_o   (set_rdc),
        .set_tx_o    (set_tx),
        .tx_start_o  (tx_start_o)
    );

    nic_irq_unit u_irq (
        .clk        (clk),
        .rst_n      (rst_n),
        .set_vec_i  (set_vec),
        .clr_we_i   (isr_we),
        .clr_mask_i (wdata),
        .clr_rst_i  (clr_rst),
        .imr_i      (imr_q),
        .isr_o      (isr_q),
        .irq_o      (irq_o)
    );

    nic_reg_file #(.STATION_BYTES(STATION_BYTES)) u_file (
        .clk         (clk),
        .rst_n       (rst_n),
        .we_i        (reg_we),
        .off_i       (eff_off),
        .wdata_i     (wdata),
        .tsr_set_i   (set_vec[ISR_TX]),
        .isr_i       (isr_q),
        .rdata_o     (file_rdata),
        .imr_o       (imr_q),
        .rcnt_zero_o (rcnt_zero),
        .tx_page_o   (tx_page_o),
        .tx_len_o    (tx_len_o)
    );

    assert_rdc_instant_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_we && !wdata[CMD_STOP] && (wdata[CMD_RRD] || wdata[CMD_RWR]) && rcnt_zero)
        |=> isr_q[ISR_RDC]);

    assert_rx_gated_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_done_i && cmd_q[CMD_STOP] && !isr_q[ISR_RX]) |=> !isr_q[ISR_RX]);

    assert_tx_event_R5: assert property (@(posedge clk) disable iff (!rst_n)
        tx_start_o |-> isr_q[ISR_TX]);

endmodule

// File: tb/nic_page_regs_tb.sv
`timescale 1ns/1ps
module nic_page_regs_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [3:0]  addr = '0;
    logic [7:0]  wdata = '0;
    logic [7:0]  rdata;
    logic        rx_done_i = 1'b0;
    logic        tx_done_i = 1'b0;
    logic        irq_o, tx_start_o;
    logic [7:0]  tx_page_o;
    logic [15:0] tx_len_o;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // bench model of the readable state
    logic [7:0] m_cmd, m_rlo, m_rhi, m_bnd, m_tpg, m_rxs, m_ds, m_im, m_cur, m_isr, m_tsr;
    logic [15:0] m_raddr;
    logic [7:0] m_sta [6];

    always #2 clk = ~clk;

    nic_page_regs dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .rdata(rdata), .rx_done_i(rx_done_i), .tx_done_i(tx_done_i),
        .irq_o(irq_o), .tx_start_o(tx_start_o), .tx_page_o(tx_page_o), .tx_len_o(tx_len_o)
    );

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got=%0h exp=%0h", req, got, exp);
        end
    endtask

    task automatic bus_write(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic bus_read(input logic [3:0] a, output logic [7:0] d);
        @(negedge clk);
        addr = a;
        #1;
        d = rdata;
    endtask

    task automatic pulse_rx();
        @(negedge clk); rx_done_i = 1'b1;
        @(negedge clk); rx_done_i = 1'b0;
    endtask

    task automatic pulse_tx();
        @(negedge clk); tx_done_i = 1'b1;
        @(negedge clk); tx_done_i = 1'b0;
    endtask

    function automatic void mdl_wr(input int p, input int a, input logic [7:0] v);
        if (p == 0) begin
            case (a)
                1: m_rlo = v;
                2: m_rhi = v;
                3: m_bnd = v;
                4: m_tpg = v;
                7: m_isr = m_isr & ~(v & 8'h7F);
                8: m_raddr[7:0] = v;
                9: m_raddr[15:8] = v;
                12: m_rxs = v;
                14: m_ds = v;
                15: m_im = v;
                default: ;
            endcase
        end else if (p == 1) begin
            if (a >= 1 && a <= 6) m_sta[a-1] = v;
            else if (a == 7) m_cur = v;
        end
    endfunction

    function automatic logic [7:0] mdl_rd(input int p, input int a);
        if (a == 0) return m_cmd;
        if (p == 0) begin
            case (a)
                3: return m_bnd;
                4: return m_tsr;
                7: return m_isr;
                8: return m_raddr[7:0];
                9: return m_raddr[15:8];
                default: return 8'h00;
            endcase
        end else if (p == 1) begin
            if (a >= 1 && a <= 6) return m_sta[a-1];
            if (a == 7) return m_cur;
            return 8'h00;
        end else if (p == 2) begin
            case (a)
                1: return m_rlo;
                2: return m_rhi;
                4: return m_tpg;
                12: return m_rxs;
                14: return m_ds;
                15: return m_im;
                default: return 8'h00;
            endcase
        end
        return 8'h00;
    endfunction

    initial begin
        #(200000 * 4);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [7:0] d;
        m_cmd = 8'h01; m_rlo = 0; m_rhi = 0; m_bnd = 0; m_tpg = 0; m_rxs = 0;
        m_ds = 0; m_im = 0; m_cur = 0; m_isr = 8'h80; m_tsr = 0; m_raddr = 0;
        for (int i = 0; i < 6; i++) m_sta[i] = 0;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R3 reset state
        bus_read(4'h0, d); chk("R3 cmd reset", d, 8'h01);
        bus_read(4'h7, d); chk("R3 status reset", d, 8'h80);
        bus_read(4'h4, d); chk("R3 tx status reset", d, 8'h00);
        chk("R3 irq reset", irq_o, 1'b0);
        chk("R3 tx_start reset", tx_start_o, 1'b0);

        // R7 bit 7 never drives irq; R6 bit 7 not clearable
        bus_write(4'hF, 8'hFF); m_im = 8'hFF;
        #1; chk("R7 bit7 masked out", irq_o, 1'b0);
        bus_write(4'h7, 8'hFF);
        bus_read(4'h7, d); chk("R6 bit7 kept", d, 8'h80);

        // R1 R10 R11 sweep: write all pages, then read all pages
        for (int p = 0; p < 4; p++) begin
            bus_write(4'h0, 8'((p << 6) | 8'h21)); m_cmd = 8'((p << 6) | 8'h21);
            for (int a = 1; a < 16; a++) begin
                logic [7:0] v;
                v = 8'((p * 37 + a * 11 + 5) & 8'hFF);
                bus_write(4'(a), v);
                mdl_wr(p, a, v);
            end
        end
        for (int p = 0; p < 4; p++) begin
            bus_write(4'h0, 8'((p << 6) | 8'h21)); m_cmd = 8'((p << 6) | 8'h21);
            for (int a = 0; a < 16; a++) begin
                bus_read(4'(a), d);
                case (p)
                    0: chk("R11 page0 read", d, mdl_rd(p, a));
                    1: chk("R10 page1 read", d, mdl_rd(p, a));
                    2: chk("R10 page2 read", d, mdl_rd(p, a));
                    default: chk("R1 page3 read", d, mdl_rd(p, a));
                endcase
            end
        end

        // R2 byte preservation on remote address
        bus_write(4'h0, 8'h21);
        bus_write(4'h8, 8'h34);
        bus_write(4'h9, 8'h12);
        bus_write(4'h8, 8'h56);
        bus_read(4'h9, d); chk("R2 raddr high kept", d, 8'h12);
        bus_read(4'h8, d); chk("R2 raddr low", d, 8'h56);
        bus_write(4'h9, 8'h9A);
        bus_read(4'h8, d); chk("R2 raddr low kept", d, 8'h56);

        // R8 rx ignored while stopped
        bus_write(4'hF, 8'h00);
        pulse_rx();
        bus_read(4'h7, d); chk("R8 rx ignored stopped", d, m_isr);

        // R3 start clears reset bit
        bus_write(4'h0, 8'h22);
        bus_read(4'h7, d); chk("R3 reset bit cleared", d, m_isr & 8'h7F);

        // R4 zero remote count
        bus_write(4'hA, 8'h00);
        bus_write(4'hB, 8'h01);
        bus_write(4'h0, 8'h0A);
        bus_read(4'h7, d); chk("R4 nonzero count no rdc", d, 8'h00);
        bus_write(4'hA, 8'h00);
        bus_write(4'h0, 8'h12);
        bus_read(4'h7, d); chk("R2 rcnt high kept", d, 8'h00);
        bus_write(4'hB, 8'h00);
        bus_write(4'h0, 8'h13);
        bus_read(4'h7, d); chk("R4 stop blocks rdc", d, 8'h00);
        bus_write(4'h0, 8'h12);
        bus_read(4'h7, d); chk("R4 zero count rdc", d, 8'h40);
        bus_write(4'h7, 8'h40);
        bus_read(4'h7, d); chk("R6 clear rdc", d, 8'h00);

        // R5 transmit
        bus_write(4'h4, 8'h46);
        bus_write(4'h5, 8'h2A);
        bus_write(4'h6, 8'h05);
        bus_write(4'h0, 8'h26);
        #1;
        chk("R5 tx_start high", tx_start_o, 1'b1);
        chk("R5 tx page", tx_page_o, 8'h46);
        chk("R2 R5 tx length", tx_len_o, 16'h052A);
        @(negedge clk); #1;
        chk("R5 tx_start one cycle", tx_start_o, 1'b0);
        bus_read(4'h0, d); chk("R5 tx bit self clears", d, 8'h22);
        bus_read(4'h4, d); chk("R5 tx status", d, 8'h01);
        bus_read(4'h7, d); chk("R5 status bit1", d, 8'h02);
        bus_write(4'h7, 8'h02);

        // R8 events while running
        pulse_rx();
        bus_read(4'h7, d); chk("R8 rx sets bit0", d, 8'h01);
        pulse_tx();
        bus_read(4'h7, d); chk("R8 tx_done sets bit1", d, 8'h03);
        bus_write(4'h7, 8'h03);
        bus_read(4'h7, d); chk("R6 clear two bits", d, 8'h00);

        // R9 set wins over simultaneous clear
        pulse_rx();
        @(negedge clk);
        wr_en = 1'b1; addr = 4'h7; wdata = 8'h01; rx_done_i = 1'b1;
        @(negedge clk);
        wr_en = 1'b0; rx_done_i = 1'b0;
        bus_read(4'h7, d); chk("R9 set beats clear", d, 8'h01);

        // R7 exhaustive mask sweep with status 0x43
        bus_write(4'h0, 8'h0A);
        pulse_tx();
        bus_read(4'h7, d); chk("R4 R8 status 0x43", d, 8'h43);
        for (int m = 0; m < 256; m++) begin
            bus_write(4'hF, 8'(m));
            #1;
            chk("R7 irq vs mask", irq_o, ((8'h43 & 8'(m) & 8'h7F) != 0));
        end
        bus_write(4'hF, 8'h01);
        bus_write(4'h7, 8'h01);
        #1; chk("R7 irq drops on clear", irq_o, 1'b0);

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule